// File: doc/BRIEF.md
# Software Trap Context-Stacking Sequencer

This block carries out the software-trap entry sequence of an 8-bit accumulator CPU core. The decoder raises `start_i` once it has recognised the one-byte trap opcode (0x83, inherent addressing, no operand bytes). The block then latches the current program counter, index register, accumulator, condition codes and stack pointer from its inputs. It forms the return address and stores the register context on a byte-wide descending stack. It sets the interrupt mask and fetches a 16-bit handler address from two fixed vector locations. At the end it presents the new program counter, stack pointer and condition codes with a one-cycle `done_o` pulse.

The memory side is a plain single-port bus with no back-pressure. The memory must accept each write in the cycle `mem_we_o` is high. It must drive `mem_rdata_i` combinationally for the address shown while `mem_re_o` is high, and the block samples it at the end of that cycle. There is no valid/ready handshake, because the trap has a fixed length. Each cycle of the sequence is a write, a read or an internal cycle, in a fixed order.

Top module: `swi_trap_seq`

## Requirements
- R1: A `start_i` sampled high while idle begins a sequence. `done_o` is high for exactly one cycle, the 10th clock cycle after the accepting edge, and `busy_o` is high for those 10 cycles.
- R2: Cycles 2 to 6 of the sequence are writes, in this order: return address low byte, return address high byte, index register, accumulator, condition codes. The return address is the input program counter plus one.
- R3: Each write goes to address {STACK_PAGE, SP}, and SP is then decremented by one, modulo 256. On completion `sp_o` equals the input SP minus 5, modulo 256.
- R4: The stacked condition-code byte carries the mask bit (bit 3) as it was on entry. `ccr_o` has bit 3 set and every other bit equal to the entry value.
- R5: Cycle 8 reads 0xFFFC (handler high byte) and cycle 9 reads 0xFFFD (handler low byte). On completion `pc_o` is {high byte, low byte}.
- R6: A `start_i` that arrives while `busy_o` is high is ignored. The bus trace and the results of the running sequence are unchanged, and the block is idle in the cycle after `done_o`.
- R7: An active-high synchronous `rst` aborts any sequence. In the next cycle `busy_o`, `done_o`, `mem_we_o` and `mem_re_o` are all low.
- R8: Cycles 1, 7 and 10 make no memory access. A sequence makes exactly 7 bus accesses, and a read and a write never occur in the same cycle.
- R9: A program counter of 0xFFFF gives a stacked return address of 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Trap request from the decoder |
| pc_i | input | 16 | Program counter of the trap opcode |
| x_i | input | 8 | Index register |
| a_i | input | 8 | Accumulator |
| ccr_i | input | 8 | Condition codes (bit 3 = interrupt mask) |
| sp_i | input | 8 | Stack pointer (low byte of stack address) |
| mem_addr_o | output | 16 | Bus address |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_re_o | output | 1 | Read strobe |
| mem_rdata_i | input | 8 | Read data, valid during a read cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | 16 | Handler address (valid with done_o) |
| sp_o | output | 8 | Stack pointer after the pushes |
| ccr_o | output | 8 | Condition codes with the mask set |

## Verification
The bus access of sequence cycle k (k = 1..10) appears after k rising edges from the accepting edge. Results and `done_o` are due in cycle 10, and idle is due in cycle 11. The driver counts falling edges from the accepting edge and checks `done_o`, `busy_o` and the results at exactly those edges. A monitor samples on every falling edge and pops one expected bus event for each strobe it sees. A missing, extra or reordered access therefore shows up as a mismatch, and any events left over at the end of the sequence show up as a failed check.

// File: rtl/swi_trap_pkg.sv
package swi_trap_pkg;
  localparam int STEP_W = 4;
  localparam int NUM_STEPS = 10;

  typedef enum logic [STEP_W-1:0] {
    ST_INC      = 4'd0,
    ST_PUSH_PCL = 4'd1,
    ST_PUSH_PCH = 4'd2,
    ST_PUSH_X   = 4'd3,
    ST_PUSH_A   = 4'd4,
    ST_PUSH_CCR = 4'd5,
    ST_MASK     = 4'd6,
    ST_VEC_HI   = 4'd7,
    ST_VEC_LO   = 4'd8,
    ST_FINISH   = 4'd9
  } step_e;
endpackage

// File: rtl/swi_step_ctrl.sv
module swi_step_ctrl
  import swi_trap_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start_i,
  output logic  accept_o,
  output logic  busy_o,
  output step_e step_o,
  output logic  done_o
);
  logic  busy_q;
  step_e step_q;

  assign accept_o = start_i && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      step_q <= ST_INC;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      step_q <= ST_INC;
    end else if (busy_q) begin
      if (step_q == ST_FINISH) begin
        busy_q <= 1'b0;
        step_q <= ST_INC;
      end else begin
        step_q <= step_e'(step_q + 4'd1);
      end
    end
  end

  assign busy_o = busy_q;
  assign step_o = step_q;
  assign done_o = busy_q && (step_q == ST_FINISH);

  // R1: accepted start opens the sequence at its first step
  assert_start_opens_R1: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> (busy_o && step_o == ST_INC));

  // R6: while running, each cycle moves exactly one step (no restart)
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> (busy_o && (4'(step_o) == 4'($past(step_o)) + 4'd1)));

  // R1: done is a single-cycle pulse
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: rtl/swi_ctx_regs.sv
module swi_ctx_regs
  import swi_trap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int I_BIT  = 3,
  localparam int PC_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic              busy_i,
  input  step_e             step_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] ccr_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [PC_W-1:0]   ret_o,
  output logic [DATA_W-1:0] x_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] ccr_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [PC_W-1:0]   vec_o
);
  localparam logic [DATA_W-1:0] I_MASK = DATA_W'(1) << I_BIT;

  logic [PC_W-1:0]   ret_q;
  logic [DATA_W-1:0] x_q, a_q, ccr_q, sp_q, vhi_q, vlo_q;
  logic              push_step;

  assign push_step = busy_i && (step_i >= ST_PUSH_PCL) && (step_i <= ST_PUSH_CCR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_q <= '0;
      x_q   <= '0;
      a_q   <= '0;
      ccr_q <= '0;
      sp_q  <= '0;
      vhi_q <= '0;
      vlo_q <= '0;
    end else if (accept_i) begin
      ret_q <= pc_i;
      x_q   <= x_i;
      a_q   <= a_i;
      ccr_q <= ccr_i;
      sp_q  <= sp_i;
    end else if (busy_i) begin
      if (step_i == ST_INC)    ret_q <= ret_q + PC_W'(1);
      if (push_step)           sp_q  <= sp_q - DATA_W'(1);
      if (step_i == ST_MASK)   ccr_q <= ccr_q | I_MASK;
      if (step_i == ST_VEC_HI) vhi_q <= rdata_i;
      if (step_i == ST_VEC_LO) vlo_q <= rdata_i;
    end
  end

  assign ret_o = ret_q;
  assign x_o   = x_q;
  assign a_o   = a_q;
  assign ccr_o = ccr_q;
  assign sp_o  = sp_q;
  assign vec_o = {vhi_q, vlo_q};

  // R3: every push step leaves SP one lower
  assert_sp_dec_R3: assert property (@(posedge clk) disable iff (rst)
    push_step |=> (sp_q == $past(sp_q) - DATA_W'(1)));

  // R4: mask step sets I and keeps the other flags
  assert_mask_set_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_i && step_i == ST_MASK) |=>
      (ccr_q[I_BIT] && ((ccr_q & ~I_MASK) == ($past(ccr_q) & ~I_MASK))));

  // R4: flags are never modified before they are stacked
  assert_ccr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_i && step_i < ST_MASK) |=> $stable(ccr_q));
endmodule

// File: rtl/swi_bus_mux.sv
module swi_bus_mux
  import swi_trap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [2*DATA_W-1:0] VEC_HI_ADDR = 16'hFFFC,
  parameter logic [2*DATA_W-1:0] VEC_LO_ADDR = 16'hFFFD,
  localparam int PC_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  step_e             step_i,
  input  logic [PC_W-1:0]   ret_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] ccr_i,
  input  logic [DATA_W-1:0] sp_i,
  output logic [PC_W-1:0]   addr_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              re_o
);
  always_comb begin
    addr_o  = '0;
    we_o    = 1'b0;
    wdata_o = '0;
    re_o    = 1'b0;
    if (busy_i) begin
      case (step_i)
        ST_PUSH_PCL: begin we_o = 1'b1; addr_o = {STACK_PAGE, sp_i}; wdata_o = ret_i[DATA_W-1:0]; end
        ST_PUSH_PCH: begin we_o = 1'b1; addr_o = {STACK_PAGE, sp_i}; wdata_o = ret_i[PC_W-1:DATA_W]; end
        ST_PUSH_X:   begin we_o = 1'b1; addr_o = {STACK_PAGE, sp_i}; wdata_o = x_i; end
        ST_PUSH_A:   begin we_o = 1'b1; addr_o = {STACK_PAGE, sp_i}; wdata_o = a_i; end
        ST_PUSH_CCR: begin we_o = 1'b1; addr_o = {STACK_PAGE, sp_i}; wdata_o = ccr_i; end
        ST_VEC_HI:   begin re_o = 1'b1; addr_o = VEC_HI_ADDR; end
        ST_VEC_LO:   begin re_o = 1'b1; addr_o = VEC_LO_ADDR; end
        default: ;
      endcase
    end
  end

  // R8: never a read and a write together
  assert_one_access_R8: assert property (@(posedge clk) disable iff (rst)
    !(we_o && re_o));

  // R7: an idle sequencer leaves the bus quiet
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !busy_i |-> (!we_o && !re_o));

  // R5: high vector read is followed by the low vector read
  assert_vec_order_R5: assert property (@(posedge clk) disable iff (rst)
    (re_o && addr_o == VEC_HI_ADDR) |=> (re_o && addr_o == VEC_LO_ADDR));
endmodule

// File: rtl/swi_trap_seq.sv
module swi_trap_seq
  import swi_trap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int I_BIT = 3,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [2*DATA_W-1:0] VEC_HI_ADDR = 16'hFFFC,
  parameter logic [2*DATA_W-1:0] VEC_LO_ADDR = 16'hFFFD
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [2*DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0]   x_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   ccr_i,
  input  logic [DATA_W-1:0]   sp_i,
  output logic [2*DATA_W-1:0] mem_addr_o,
  output logic                mem_we_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic                mem_re_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [2*DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0]   sp_o,
  output logic [DATA_W-1:0]   ccr_o
);
  localparam int PC_W = 2 * DATA_W;

  logic              accept, busy;
  step_e             step;
  logic [PC_W-1:0]   ret, vec;
  logic [DATA_W-1:0] x_q, a_q, ccr_q, sp_q;

  swi_step_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .accept_o(accept),
    .busy_o(busy), .step_o(step), .done_o(done_o)
  );

  swi_ctx_regs #(.DATA_W(DATA_W), .I_BIT(I_BIT)) u_ctx (
    .clk(clk), .rst(rst), .accept_i(accept), .busy_i(busy), .step_i(step),
    .pc_i(pc_i), .x_i(x_i), .a_i(a_i), .ccr_i(ccr_i), .sp_i(sp_i),
    .rdata_i(mem_rdata_i), .ret_o(ret), .x_o(x_q), .a_o(a_q),
    .ccr_o(ccr_q), .sp_o(sp_q), .vec_o(vec)
  );

  swi_bus_mux #(.DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE),
                .VEC_HI_ADDR(VEC_HI_ADDR), .VEC_LO_ADDR(VEC_LO_ADDR)) u_bus (
    .clk(clk), .rst(rst), .busy_i(busy), .step_i(step), .ret_i(ret),
    .x_i(x_q), .a_i(a_q), .ccr_i(ccr_q), .sp_i(sp_q),
    .addr_o(mem_addr_o), .we_o(mem_we_o), .wdata_o(mem_wdata_o), .re_o(mem_re_o)
  );

  assign busy_o = busy;
  assign pc_o   = vec;
  assign sp_o   = sp_q;
  assign ccr_o  = ccr_q;

  // R4: completion always reports the mask set
  assert_done_masked_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ccr_o[I_BIT]);
endmodule

// File: tb/swi_trap_seq_tb.sv
module swi_trap_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [7:0] x_i = '0, a_i = '0, ccr_i = '0, sp_i = '0;
  logic [15:0] mem_addr_o;
  logic mem_we_o, mem_re_o, busy_o, done_o;
  logic [7:0] mem_wdata_o, mem_rdata_i, sp_o, ccr_o;
  logic [15:0] pc_o;
  logic [7:0] vhi = '0, vlo = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_off = 1'b0;

  typedef struct {
    bit        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    string     tag;
  } ev_t;
  ev_t expq[$];

  always #5 clk = ~clk;

  assign mem_rdata_i = (mem_addr_o == 16'hFFFC) ? vhi :
                       (mem_addr_o == 16'hFFFD) ? vlo : 8'h00;

  swi_trap_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .pc_i(pc_i), .x_i(x_i),
    .a_i(a_i), .ccr_i(ccr_i), .sp_i(sp_i), .mem_addr_o(mem_addr_o),
    .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o), .mem_re_o(mem_re_o),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
    .pc_o(pc_o), .sp_o(sp_o), .ccr_o(ccr_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every bus strobe consumes one expected event
  always @(negedge clk) begin
    if (!mon_off && (mem_we_o || mem_re_o)) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R8 unexpected access", mem_addr_o, 0);
      end else begin
        ev_t e;
        e = expq.pop_front();
        chk(mem_we_o == e.wr && mem_re_o == !e.wr, {e.tag, " kind"}, mem_we_o, e.wr);
        chk(mem_addr_o == e.addr, {e.tag, " addr"}, mem_addr_o, e.addr);
        if (e.wr) chk(mem_wdata_o == e.data, {e.tag, " data"}, mem_wdata_o, e.data);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_trap(input logic [15:0] pc, input logic [7:0] x, input logic [7:0] a,
                          input logic [7:0] ccr, input logic [7:0] sp,
                          input logic [7:0] hi, input logic [7:0] lo, input bit poke);
    logic [15:0] ret = pc + 16'd1;
    vhi = hi; vlo = lo;
    expq.push_back('{1'b1, {8'h01, sp},         ret[7:0],  "R2 pcl"});
    expq.push_back('{1'b1, {8'h01, sp - 8'd1},  ret[15:8], "R2 pch R9"});
    expq.push_back('{1'b1, {8'h01, sp - 8'd2},  x,         "R2 x R3"});
    expq.push_back('{1'b1, {8'h01, sp - 8'd3},  a,         "R2 a R3"});
    expq.push_back('{1'b1, {8'h01, sp - 8'd4},  ccr,       "R4 stacked ccr"});
    expq.push_back('{1'b0, 16'hFFFC,            8'h00,     "R5 vec hi"});
    expq.push_back('{1'b0, 16'hFFFD,            8'h00,     "R5 vec lo"});
    @(negedge clk);
    pc_i = pc; x_i = x; a_i = a; ccr_i = ccr; sp_i = sp; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 10; k++) begin
      chk(busy_o == 1'b1, "R1 busy", busy_o, 1);
      chk(done_o == (k == 9), "R1 done timing", done_o, (k == 9));
      if (k == 0 || k == 6 || k == 9)
        chk(!mem_we_o && !mem_re_o, "R8 internal cycle", {mem_we_o, mem_re_o}, 0);
      if (poke && k == 3) begin
        pc_i = 16'h1234; x_i = 8'hEE; sp_i = 8'h55; start_i = 1'b1;  // R6 attempt
      end
      if (poke && k == 5) start_i = 1'b0;
      if (k == 9) begin
        chk(pc_o == {hi, lo}, "R5 pc_o", pc_o, {hi, lo});
        chk(sp_o == sp - 8'd5, "R3 sp_o", sp_o, sp - 8'd5);
        chk(ccr_o == (ccr | 8'h08), "R4 ccr_o", ccr_o, ccr | 8'h08);
      end
      if (k < 9) @(negedge clk);
    end
    @(negedge clk);
    chk(!busy_o && !done_o, "R6 idle after done", busy_o, 0);
    chk(expq.size() == 0, "R8 access count", expq.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy_o && !done_o && !mem_we_o && !mem_re_o, "R7 reset state",
        {busy_o, done_o, mem_we_o, mem_re_o}, 0);
    rst = 1'b0;
    run_trap(16'h0340, 8'h11, 8'h22, 8'hE0, 8'hFF, 8'h12, 8'h34, 1'b0);
    run_trap(16'h8001, 8'hA5, 8'h5A, 8'hEF, 8'h80, 8'hC0, 8'h0F, 1'b0);
    run_trap(16'hFFFF, 8'h00, 8'hFF, 8'hE7, 8'h02, 8'h00, 8'hFF, 1'b0);  // R9 and R3 wrap
    run_trap(16'h1FFE, 8'h3C, 8'hC3, 8'hF5, 8'h40, 8'h9A, 8'hBC, 1'b1);  // R6
    // R7: reset in mid sequence
    mon_off = 1'b1;
    @(negedge clk);
    pc_i = 16'h0100; sp_i = 8'h70; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !mem_we_o && !mem_re_o, "R7 abort",
        {busy_o, done_o, mem_we_o, mem_re_o}, 0);
    rst = 1'b0;
    mon_off = 1'b0;
    run_trap(16'h7777, 8'h01, 8'h02, 8'hE8, 8'h10, 8'h44, 8'h55, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule